// File: doc/BRIEF.md
# Secondary Cache Tag Controller (Direct-Mapped)

This block holds the line state of a direct-mapped secondary cache that sits between a CPU bus and main memory. For each CPU read or write request it compares the address against the stored tag of the one line the address can occupy. It then reports whether the access hits and whether a line is allocated. It also flags whether a dirty victim has to be written back first, and whether the access has to go on to memory. The data array, its burst timing and the memory controller are outside the block. They act on these indications.

Configuration inputs choose the cache size (off, or one of four sizes, each twice the previous), the write policy (write-back or write-through) and a cacheable window. They also set one firmware region that can be made cacheable and write-protected. The tag store is internal. Its depth is scaled by the parameter `BASE_IDX_W`: the smallest size has `2**BASE_IDX_W` lines and each larger size doubles that. Lines are 32 bytes and every stored tag is 8 bits wide.

Top module: `l2_tag_ctrl`

## Requirements
- R1: After reset every line is invalid, `rsp_valid` is low and all response flags are low whenever `rsp_valid` is low.
- R2: A request accepted while `req_valid` is high produces exactly one response, with `rsp_valid` high, on the next clock edge.
- R3: A read miss inside the cacheable space allocates the line (`rsp_alloc`=1, `rsp_fwd`=1). A later read of any byte of that 32-byte line hits, with `rsp_fwd`=0.
- R4: Direct mapping: two addresses with the same index bits and different tag bits evict each other.
- R5: In write-back mode (`cfg_wb`=1) a write hit marks the line dirty and is not forwarded. A later allocation into that line raises `rsp_wb` and puts the old line address on `rsp_victim_addr`, built as old tag and index.
- R6: In write-through mode (`cfg_wb`=0) every write is forwarded and lines stay clean, so their eviction never raises `rsp_wb`.
- R7: A write miss forwards (`rsp_fwd`=1) and never allocates.
- R8: `cfg_size` encodes 0=off, 1..4 = smallest..largest size, and 5..7 = off. When the size is off, every access misses, forwards and does not allocate.
- R9: An address at or above `cfg_win_top`, or at or above the tag span `2**(5+index_width+8)`, is uncacheable unless it is in a cacheable firmware region. Such an access misses, forwards and does not allocate.
- R10: With `cfg_fw_cache`=1 the range [`cfg_fw_base`, `cfg_fw_top`) is cacheable even outside the window.
- R11: With `cfg_fw_wp`=1 a write into the firmware range never makes its line dirty and never allocates. It is forwarded, and a hit is still reported.
- R12: For size code k the index is address bits [5 +: BASE_IDX_W+k-1] and the tag is the 8 bits directly above the index.
- R13: Any change of `cfg_size` or `cfg_wb` invalidates all lines on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| cfg_size | input | 3 | Size code (0 off, 1..4 sizes) |
| cfg_wb | input | 1 | 1 = write-back, 0 = write-through |
| cfg_win_top | input | ADDR_W | Exclusive upper bound of cacheable window |
| cfg_fw_base | input | ADDR_W | Firmware region start (inclusive) |
| cfg_fw_top | input | ADDR_W | Firmware region end (exclusive) |
| cfg_fw_cache | input | 1 | Firmware region cacheable |
| cfg_fw_wp | input | 1 | Firmware region write-protected |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Access hit a valid line |
| rsp_alloc | output | 1 | Line allocated with the request's tag |
| rsp_wb | output | 1 | Dirty victim must be written back |
| rsp_victim_addr | output | ADDR_W | Line address of the victim |
| rsp_fwd | output | 1 | Access must go to main memory |

## Verification
Every response is registered once, so its flags and victim address appear one edge after the request edge. The line-state update made at that same edge is seen by the very next request. The bench drives each request at a falling edge, drops it at the next falling edge and samples the response there. Between those two falling edges exactly one rising edge has passed. A configuration change is likewise applied at a falling edge and followed by one idle cycle, so the invalidation edge has passed before the next request.

// File: rtl/l2tc_pkg.sv
`timescale 1ns/1ps
package l2tc_pkg;

    localparam int OFFS_W = 5;   // 32-byte lines
    localparam int TAG_W  = 8;   // stored tag width

    typedef struct packed {
        logic hit;
        logic alloc;
        logic wb;
        logic fwd;
    } l2tc_resp_t;

    typedef struct packed {
        logic install;    // write new tag, valid, clean
        logic set_dirty;  // mark line modified
    } l2tc_upd_t;

    // Size code to doubling step: 0 = disabled, 1..4 = sizes, others disabled.
    function automatic logic [2:0] size_step(input logic [2:0] code);
        return (code <= 3'd4) ? code : 3'd0;
    endfunction

    // Number of index bits for a given step.
    function automatic int idx_width(input int base_w, input logic [2:0] step);
        return (step == 3'd0) ? base_w : base_w + int'(step) - 1;
    endfunction

    // Lowest tag bit position for a given step.
    function automatic int tag_shift(input int base_w, input logic [2:0] step);
        return OFFS_W + idx_width(base_w, step);
    endfunction

endpackage

// File: rtl/l2tc_decode.sv
`timescale 1ns/1ps
module l2tc_decode
    import l2tc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BASE_IDX_W = 4
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [2:0]              step,
    input  logic [ADDR_W-1:0]       win_top,
    input  logic [ADDR_W-1:0]       fw_base,
    input  logic [ADDR_W-1:0]       fw_top,
    input  logic                    fw_cache,
    input  logic                    fw_wp,
    output logic [BASE_IDX_W+2:0]   idx,
    output logic [TAG_W-1:0]        tag,
    output logic                    cacheable,
    output logic                    protect
);
    localparam int IDX_MAX_W = BASE_IDX_W + 3;

    logic [ADDR_W-1:0] line_addr;
    logic              span_ok;
    logic              in_win;
    logic              in_fw;

    always_comb begin
        int iw;
        int sh;
        iw        = idx_width(BASE_IDX_W, step);
        sh        = tag_shift(BASE_IDX_W, step);
        line_addr = addr >> OFFS_W;
        for (int b = 0; b < IDX_MAX_W; b++) begin
            idx[b] = line_addr[b] & (b < iw);
        end
        tag       = TAG_W'(addr >> sh);
        span_ok   = ((addr >> (sh + TAG_W)) == '0);
        in_win    = (addr < win_top);
        in_fw     = (addr >= fw_base) && (addr < fw_top);
        cacheable = (step != 3'd0) && span_ok && (in_win || (fw_cache && in_fw));
        protect   = fw_wp && in_fw;
    end

endmodule

// File: rtl/l2tc_tagstore.sv
`timescale 1ns/1ps
module l2tc_tagstore
    import l2tc_pkg::*;
#(
    parameter int IDX_W = 7,
    localparam int LINES = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [IDX_W-1:0]   idx,
    input  logic [TAG_W-1:0]   new_tag,
    input  l2tc_upd_t          upd,
    output logic               line_valid,
    output logic               line_dirty,
    output logic [TAG_W-1:0]   line_tag,
    output logic [LINES-1:0]   valid_bits
);
    logic             valid_q [LINES];
    logic             dirty_q [LINES];
    logic [TAG_W-1:0] tag_q   [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic sel;
        assign sel = (idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                valid_q[i] <= 1'b0;
                dirty_q[i] <= 1'b0;
            end else if (sel && upd.install) begin
                valid_q[i] <= 1'b1;
                dirty_q[i] <= 1'b0;
            end else if (sel && upd.set_dirty) begin
                dirty_q[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q[i] <= '0;
            end else if (sel && upd.install && !flush) begin
                tag_q[i] <= new_tag;
            end
        end

        assign valid_bits[i] = valid_q[i];
    end

    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
    assign line_tag   = tag_q[idx];

endmodule

// File: rtl/l2tc_policy.sv
`timescale 1ns/1ps
module l2tc_policy
    import l2tc_pkg::*;
(
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             cacheable,
    input  logic             protect,
    input  logic             wb_mode,
    input  logic             flush,
    input  logic             line_valid,
    input  logic             line_dirty,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    output l2tc_resp_t       resp,
    output l2tc_upd_t        upd
);
    logic hit;
    logic keep_local;

    always_comb begin
        resp = '0;
        upd  = '0;
        hit  = req_valid && cacheable && !flush && line_valid && (line_tag == req_tag);
        keep_local = hit && wb_mode && !protect;
        if (req_valid) begin
            resp.hit = hit;
            if (req_write) begin
                resp.fwd      = !keep_local;
                upd.set_dirty = keep_local;
            end else begin
                resp.fwd    = !hit;
                resp.alloc  = cacheable && !hit && !flush;
                resp.wb     = resp.alloc && line_valid && line_dirty;
                upd.install = resp.alloc;
            end
        end
    end

endmodule

// File: rtl/l2_tag_ctrl.sv
`timescale 1ns/1ps
module l2_tag_ctrl
    import l2tc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BASE_IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        cfg_size,
    input  logic              cfg_wb,
    input  logic [ADDR_W-1:0] cfg_win_top,
    input  logic [ADDR_W-1:0] cfg_fw_base,
    input  logic [ADDR_W-1:0] cfg_fw_top,
    input  logic              cfg_fw_cache,
    input  logic              cfg_fw_wp,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_alloc,
    output logic              rsp_wb,
    output logic [ADDR_W-1:0] rsp_victim_addr,
    output logic              rsp_fwd
);
    localparam int IDX_W = BASE_IDX_W + 3;
    localparam int LINES = 1 << IDX_W;

    logic [2:0]        step;
    logic [2:0]        step_q;
    logic              wb_q;
    logic              flush_w;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic              cacheable;
    logic              protect;
    logic              line_valid;
    logic              line_dirty;
    logic [TAG_W-1:0]  line_tag;
    logic [LINES-1:0]  valid_bits;
    l2tc_resp_t        resp;
    l2tc_upd_t         upd;
    logic [ADDR_W-1:0] victim;

    assign step = size_step(cfg_size);

    // Configuration copy follows the inputs every cycle, so reset leaves no
    // pending difference; a later difference triggers one invalidation edge.
    always_ff @(posedge clk) begin
        step_q <= step;
        wb_q   <= cfg_wb;
    end
    assign flush_w = !rst && ((step != step_q) || (cfg_wb != wb_q));

    l2tc_decode #(.ADDR_W(ADDR_W), .BASE_IDX_W(BASE_IDX_W)) u_decode (
        .addr      (req_addr),
        .step      (step),
        .win_top   (cfg_win_top),
        .fw_base   (cfg_fw_base),
        .fw_top    (cfg_fw_top),
        .fw_cache  (cfg_fw_cache),
        .fw_wp     (cfg_fw_wp),
        .idx       (idx),
        .tag       (tag),
        .cacheable (cacheable),
        .protect   (protect)
    );

    l2tc_tagstore #(.IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush_w),
        .idx        (idx),
        .new_tag    (tag),
        .upd        (upd),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag),
        .valid_bits (valid_bits)
    );

    l2tc_policy u_policy (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .cacheable  (cacheable),
        .protect    (protect),
        .wb_mode    (cfg_wb),
        .flush      (flush_w),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag),
        .req_tag    (tag),
        .resp       (resp),
        .upd        (upd)
    );

    always_comb begin
        victim = (ADDR_W'(line_tag) << tag_shift(BASE_IDX_W, step))
               | (ADDR_W'(idx) << OFFS_W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid       <= 1'b0;
            rsp_hit         <= 1'b0;
            rsp_alloc       <= 1'b0;
            rsp_wb          <= 1'b0;
            rsp_fwd         <= 1'b0;
            rsp_victim_addr <= '0;
        end else begin
            rsp_valid       <= req_valid;
            rsp_hit         <= resp.hit;
            rsp_alloc       <= resp.alloc;
            rsp_wb          <= resp.wb;
            rsp_fwd         <= resp.fwd;
            rsp_victim_addr <= resp.wb ? victim : '0;
        end
    end

endmodule

// File: rtl/l2tc_checker.sv
`timescale 1ns/1ps
module l2tc_checker #(
    parameter int LINES = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_write,
    input logic [2:0]       cfg_size,
    input logic             cfg_wb,
    input logic             flush,
    input logic [LINES-1:0] valid_bits,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_alloc,
    input logic             rsp_wb,
    input logic             rsp_fwd
);
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_hit || rsp_alloc || rsp_wb || rsp_fwd));

    a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));

    a_r3_alloc_on_miss: assert property (@(posedge clk) disable iff (rst)
        rsp_alloc |-> (rsp_valid && !rsp_hit && rsp_fwd));

    a_r3_read_hit_local: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit && !$past(req_write)) |-> !rsp_fwd);

    a_r5_victim_with_alloc: assert property (@(posedge clk) disable iff (rst)
        rsp_wb |-> rsp_alloc);

    a_r6_wt_write_forwards: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_write) && !$past(cfg_wb)) |-> rsp_fwd);

    a_r7_no_write_alloc: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_write)) |-> !rsp_alloc);

    a_r8_off_no_hit: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && ($past(cfg_size) == 3'd0)) |-> (!rsp_hit && !rsp_alloc && rsp_fwd));

    a_r13_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_bits == '0));
endmodule

bind l2_tag_ctrl l2tc_checker #(.LINES(LINES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .cfg_size   (cfg_size),
    .cfg_wb     (cfg_wb),
    .flush      (flush_w),
    .valid_bits (valid_bits),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_alloc  (rsp_alloc),
    .rsp_wb     (rsp_wb),
    .rsp_fwd    (rsp_fwd)
);

// File: tb/l2_tag_ctrl_tb.sv
`timescale 1ns/1ps
module l2_tag_ctrl_tb;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [2:0]        cfg_size = 3'd1;
    logic              cfg_wb = 1'b1;
    logic [ADDR_W-1:0] cfg_win_top = 32'h0001_0000;
    logic [ADDR_W-1:0] cfg_fw_base = 32'h0001_8000;
    logic [ADDR_W-1:0] cfg_fw_top  = 32'h0001_A000;
    logic              cfg_fw_cache = 1'b1;
    logic              cfg_fw_wp = 1'b1;
    logic              rsp_valid, rsp_hit, rsp_alloc, rsp_wb, rsp_fwd;
    logic [ADDR_W-1:0] rsp_victim_addr;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    l2_tag_ctrl #(.ADDR_W(ADDR_W), .BASE_IDX_W(4)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .cfg_size(cfg_size), .cfg_wb(cfg_wb),
        .cfg_win_top(cfg_win_top), .cfg_fw_base(cfg_fw_base),
        .cfg_fw_top(cfg_fw_top), .cfg_fw_cache(cfg_fw_cache),
        .cfg_fw_wp(cfg_fw_wp), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_alloc(rsp_alloc), .rsp_wb(rsp_wb),
        .rsp_victim_addr(rsp_victim_addr), .rsp_fwd(rsp_fwd)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the request edge.
    task automatic look(input string rq, input logic w, input logic [31:0] a,
                        input logic eh, input logic ea, input logic ew, input logic ef);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        chk("R2", "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(rq, "hit",   32'(rsp_hit),   32'(eh));
        chk(rq, "alloc", 32'(rsp_alloc), 32'(ea));
        chk(rq, "wb",    32'(rsp_wb),    32'(ew));
        chk(rq, "fwd",   32'(rsp_fwd),   32'(ef));
    endtask

    task automatic set_cfg(input logic [2:0] sz, input logic wb);
        cfg_size = sz;
        cfg_wb   = wb;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1", "flags after reset", 32'({rsp_hit, rsp_alloc, rsp_wb, rsp_fwd}), 32'd0);
        look("R1", 1'b0, 32'h40, 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_read_hit;
        look("R3", 1'b0, 32'h40, 1'b1, 1'b0, 1'b0, 1'b0);
        look("R3", 1'b0, 32'h5C, 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R2", "rsp_valid idle", 32'(rsp_valid), 32'd0);
        chk("R1", "flags idle", 32'({rsp_hit, rsp_alloc, rsp_wb, rsp_fwd}), 32'd0);
    endtask

    task automatic t_conflict;
        look("R4", 1'b0, 32'h240, 1'b0, 1'b1, 1'b0, 1'b1);
        look("R4", 1'b0, 32'h40,  1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_write_back;
        look("R5", 1'b1, 32'h40,  1'b1, 1'b0, 1'b0, 1'b0);
        look("R5", 1'b0, 32'h240, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R5", "victim", rsp_victim_addr, 32'h40);
        look("R5", 1'b0, 32'h40,  1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_write_miss;
        look("R7", 1'b1, 32'h80, 1'b0, 1'b0, 1'b0, 1'b1);
        look("R7", 1'b0, 32'h80, 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_write_through;
        set_cfg(3'd1, 1'b0);
        look("R13", 1'b0, 32'h40, 1'b0, 1'b1, 1'b0, 1'b1);
        look("R6",  1'b1, 32'h40, 1'b1, 1'b0, 1'b0, 1'b1);
        look("R6",  1'b0, 32'h240, 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_window;
        look("R9", 1'b0, 32'h12000, 1'b0, 1'b0, 1'b0, 1'b1);
        look("R9", 1'b0, 32'h12000, 1'b0, 1'b0, 1'b0, 1'b1);
        cfg_win_top = 32'hFFFF_FFFF;
        look("R9", 1'b0, 32'h20040, 1'b0, 1'b0, 1'b0, 1'b1);
        look("R9", 1'b0, 32'h12000, 1'b0, 1'b1, 1'b0, 1'b1);
        cfg_win_top = 32'h0001_0000;
    endtask

    task automatic t_firmware;
        set_cfg(3'd1, 1'b1);
        look("R10", 1'b0, 32'h18040, 1'b0, 1'b1, 1'b0, 1'b1);
        look("R10", 1'b0, 32'h18040, 1'b1, 1'b0, 1'b0, 1'b0);
        look("R11", 1'b1, 32'h18040, 1'b1, 1'b0, 1'b0, 1'b1);
        look("R11", 1'b0, 32'h18240, 1'b0, 1'b1, 1'b0, 1'b1);
        look("R11", 1'b1, 32'h18840, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_off;
        set_cfg(3'd0, 1'b1);
        look("R8", 1'b0, 32'h40, 1'b0, 1'b0, 1'b0, 1'b1);
        look("R8", 1'b0, 32'h40, 1'b0, 1'b0, 1'b0, 1'b1);
        set_cfg(3'd6, 1'b1);
        look("R8", 1'b0, 32'h40, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_size;
        set_cfg(3'd2, 1'b1);
        look("R12", 1'b0, 32'h40,  1'b0, 1'b1, 1'b0, 1'b1);
        look("R12", 1'b0, 32'h240, 1'b0, 1'b1, 1'b0, 1'b1);
        look("R12", 1'b0, 32'h40,  1'b1, 1'b0, 1'b0, 1'b0);
        look("R12", 1'b0, 32'h440, 1'b0, 1'b1, 1'b0, 1'b1);
        look("R12", 1'b1, 32'h440, 1'b1, 1'b0, 1'b0, 1'b0);
        look("R12", 1'b0, 32'h40,  1'b0, 1'b1, 1'b1, 1'b1);
        chk("R12", "victim", rsp_victim_addr, 32'h440);
        cfg_win_top = 32'hFFFF_FFFF;
        look("R12", 1'b0, 32'h20040, 1'b0, 1'b1, 1'b0, 1'b1);
        cfg_win_top = 32'h0001_0000;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_hit();
        t_conflict();
        t_write_back();
        t_write_miss();
        t_write_through();
        t_window();
        t_firmware();
        t_off();
        t_size();
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule